// File: doc/BRIEF.md
# Frobenius Class Canonicalizer

This block takes an elliptic-curve point over GF(2^m) whose two coordinates are already held in normal-basis form. It picks one fixed representative of the point's Frobenius equivalence class. In normal basis, repeated squaring of a coordinate is a cyclic rotation of its bit vector. The m members of the class are therefore produced by rewiring alone, and no squarer logic is needed. Each rotation of x is scored by its most significant t bits, read as an unsigned integer. A pipelined binary tree of comparators, with one register per tree level, finds the lowest score. The y coordinate is rotated by the winning amount. The winning rotation count is also output, so that logic elsewhere can apply the matching scalar update.

Points enter and leave on valid/ready streams. An input beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. The pipeline moves as one unit. When the last stage holds a result and `out_ready` is low, every stage freezes, the output holds steady and `in_ready` drops. `in_ready` is high whenever the last stage is empty or is being drained in the same cycle. Without stalls the latency is fixed and the block takes one point per clock.

Top module: `frobenius_canon`

## Requirements
- R1: Rotation by s is defined as out[b] = v[(b - s) mod M], which is a left rotation. `out_x` is the input x rotated by `out_idx` under this definition.
- R2: `out_idx` selects a rotation whose score is the lowest of all M rotations of x. The score is bits [M-1 : M-T] of the rotation, read as an unsigned integer.
- R3: When several rotations share the lowest score, the lowest rotation count wins. Bits below the top T bits have no effect on the choice.
- R4: `out_y` is the input y rotated by the same `out_idx` as x.
- R5: With `out_ready` held high, a result appears exactly ceil(log2 M) + 1 clocks after acceptance. This is 8 clocks for M = 113.
- R6: While `out_valid` is high and `out_ready` is low, the outputs hold stable and `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R7: Every accepted point yields exactly one result, in acceptance order, and no other result appears.
- R8: Reset (active low) empties the pipeline. `out_valid` reads 0 and `in_ready` reads 1 after reset, and points in flight are discarded.
- R9: `out_idx` is always less than M when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input point present |
| in_ready | output | 1 | Block can take a point this cycle |
| in_x | input | M | x coordinate, normal basis |
| in_y | input | M | y coordinate, normal basis |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_x | output | M | Canonical x (lowest-scoring rotation) |
| out_y | output | M | y rotated by the same count |
| out_idx | output | ceil(log2 M) | Chosen rotation count |

## Verification
On every cycle, the assertions check the stall contract: outputs hold while stalled, `in_ready` is low under a stall and high when the pipeline is empty. They also check that the rotation count is in range, and that the emitted x scores no higher than its own one-step rotation, which is another member of the class. Only the bench scenarios can show the exact choice among tied scores and that bits below the top slice are ignored. The same holds for the y rotation, the fixed latency, ordering under random back-pressure, and flushing on reset. The bench compares against a rotation model written from the requirements.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int unsigned FCC_M_DEFAULT = 113;
  localparam int unsigned FCC_T_DEFAULT = 70;

  // depth of the comparison tree for a field of size m
  function automatic int unsigned fcc_levels(int unsigned m);
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/fcc_rot_bank.sv
// Forms the score (top T bits) of every cyclic rotation of x by wiring only.
// Leaves beyond M are padded with all-ones so they never win.
module fcc_rot_bank #(
  parameter int unsigned M     = 113,
  parameter int unsigned T     = 70,
  parameter int unsigned NLEAF = 128
) (
  input  logic [M-1:0]       x,
  output logic [NLEAF*T-1:0] keys
);
  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    if (i < M) begin : g_real
      for (genvar k = 0; k < T; k++) begin : g_bit
        // bit (M-T+k) of rotation i comes from x[(M-T+k-i) mod M]
        assign keys[i*T + k] = x[((M - T + k) + M - i) % M];
      end
    end else begin : g_pad
      assign keys[i*T +: T] = '1;
    end
  end
endmodule

// File: rtl/fcc_min_level.sv
// One registered level of the minimum tree: NIN candidates in, NIN/2 out.
// The right (higher index) candidate wins only on a strictly lower score.
module fcc_min_level #(
  parameter int unsigned T   = 70,
  parameter int unsigned IW  = 7,
  parameter int unsigned NIN = 128
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [NIN*T-1:0]      k_i,
  input  logic [NIN*IW-1:0]     i_i,
  output logic [NIN/2*T-1:0]    k_o,
  output logic [NIN/2*IW-1:0]   i_o
);
  localparam int unsigned NOUT = NIN / 2;

  for (genvar n = 0; n < NOUT; n++) begin : g_node
    logic [T-1:0]  kl, kr, kq;
    logic [IW-1:0] il, ir, iq;
    logic          pick_r;

    assign kl     = k_i[(2*n)*T +: T];
    assign kr     = k_i[(2*n+1)*T +: T];
    assign il     = i_i[(2*n)*IW +: IW];
    assign ir     = i_i[(2*n+1)*IW +: IW];
    assign pick_r = (kr < kl);

    always_ff @(posedge clk) begin
      if (en) begin
        kq <= pick_r ? kr : kl;
        iq <= pick_r ? ir : il;
      end
    end

    assign k_o[n*T +: T]   = kq;
    assign i_o[n*IW +: IW] = iq;
  end
endmodule

// File: rtl/fcc_rot_sel.sv
// Variable cyclic left rotation: out[b] = v[(b - sh) mod M], sh < M.
module fcc_rot_sel #(
  parameter int unsigned M  = 113,
  parameter int unsigned IW = 7
) (
  input  logic [M-1:0]  v,
  input  logic [IW-1:0] sh,
  output logic [M-1:0]  r
);
  logic [2*M-1:0] dbl;

  always_comb begin
    dbl = {v, v} << sh;
    r   = dbl[2*M-1:M];
  end
endmodule

// File: rtl/frobenius_canon.sv
module frobenius_canon
  import fcc_pkg::*;
#(
  parameter  int unsigned M     = FCC_M_DEFAULT,
  parameter  int unsigned T     = FCC_T_DEFAULT,
  localparam int unsigned LVL   = fcc_levels(M),
  localparam int unsigned IW    = LVL,
  localparam int unsigned NLEAF = 1 << LVL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [M-1:0]  in_x,
  input  logic [M-1:0]  in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [M-1:0]  out_x,
  output logic [M-1:0]  out_y,
  output logic [IW-1:0] out_idx
);
  // stage 0 captures the point; tree levels add LVL more registers
  logic           adv;
  logic [LVL:0]   sb_v;
  logic [M-1:0]   sb_x [LVL+1];
  logic [M-1:0]   sb_y [LVL+1];

  assign adv      = ~sb_v[LVL] | out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_v <= '0;
    end else if (adv) begin
      sb_v <= {sb_v[LVL-1:0], in_valid};
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      sb_x[0] <= in_x;
      sb_y[0] <= in_y;
      for (int l = 1; l <= LVL; l++) begin
        sb_x[l] <= sb_x[l-1];
        sb_y[l] <= sb_y[l-1];
      end
    end
  end

  // candidate scores and their rotation counts
  logic [NLEAF*T-1:0]  leaf_key;
  logic [NLEAF*IW-1:0] leaf_idx;

  fcc_rot_bank #(.M(M), .T(T), .NLEAF(NLEAF)) u_bank (
    .x    (sb_x[0]),
    .keys (leaf_key)
  );

  for (genvar i = 0; i < NLEAF; i++) begin : g_lidx
    assign leaf_idx[i*IW +: IW] = IW'(i);
  end

  // registered tree levels down to two survivors
  for (genvar l = 0; l < LVL - 1; l++) begin : g_lvl
    localparam int unsigned NIN = NLEAF >> l;
    logic [NIN*T-1:0]    k_i;
    logic [NIN*IW-1:0]   i_i;
    logic [NIN/2*T-1:0]  k_o;
    logic [NIN/2*IW-1:0] i_o;

    if (l == 0) begin : g_src_leaf
      assign k_i = leaf_key;
      assign i_i = leaf_idx;
    end else begin : g_src_prev
      assign k_i = g_lvl[l-1].k_o;
      assign i_i = g_lvl[l-1].i_o;
    end

    fcc_min_level #(.T(T), .IW(IW), .NIN(NIN)) u_lvl (
      .clk (clk),
      .en  (adv),
      .k_i (k_i),
      .i_i (i_i),
      .k_o (k_o),
      .i_o (i_o)
    );
  end

  // root: only the winning count is kept
  logic [2*T-1:0]  root_k;
  logic [2*IW-1:0] root_i;
  logic [IW-1:0]   idx_q;

  if (LVL >= 2) begin : g_root_tree
    assign root_k = g_lvl[LVL-2].k_o;
    assign root_i = g_lvl[LVL-2].i_o;
  end else begin : g_root_leaf
    assign root_k = leaf_key;
    assign root_i = leaf_idx;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      idx_q <= (root_k[2*T-1 -: T] < root_k[T-1:0]) ? root_i[2*IW-1 -: IW]
                                                     : root_i[IW-1:0];
    end
  end

  // apply the chosen rotation to both carried coordinates
  fcc_rot_sel #(.M(M), .IW(IW)) u_rot_x (
    .v  (sb_x[LVL]),
    .sh (idx_q),
    .r  (out_x)
  );

  fcc_rot_sel #(.M(M), .IW(IW)) u_rot_y (
    .v  (sb_y[LVL]),
    .sh (idx_q),
    .r  (out_y)
  );

  assign out_valid = sb_v[LVL];
  assign out_idx   = idx_q;
endmodule

// File: rtl/frobenius_canon_chk.sv
module frobenius_canon_chk #(
  parameter int unsigned M  = 113,
  parameter int unsigned T  = 70,
  parameter int unsigned IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [M-1:0]  out_x,
  input logic [M-1:0]  out_y,
  input logic [IW-1:0] out_idx
);
  // the emitted x rotated one more step is another class member
  logic [M-1:0] x_r1;
  assign x_r1 = {out_x[M-2:0], out_x[M-1]};

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_idx));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_idx) < M);

  // R2
  min_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_x[M-1 -: T] <= x_r1[M-1 -: T]);
endmodule

bind frobenius_canon frobenius_canon_chk #(.M(M), .T(T), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_idx   (out_idx)
);

// File: tb/frobenius_canon_tb.sv
module frobenius_canon_tb;
  localparam int M   = 113;
  localparam int T   = 70;
  localparam int LAT = 8;
  localparam int NV  = 7;

  // table: x, y, hand-derived winning rotation count
  localparam logic [M-1:0] TX [NV] = '{
    113'd0,                 // all scores equal -> 0 (R3)
    {113{1'b1}},            // all scores equal -> 0 (R3)
    {1'b1, 112'd0},         // top bit moves to bit 0 at s=1 -> 1
    113'd1,                 // score already zero at s=0 -> 0
    {2'b11, 111'd0},        // both bits low only at s=2 -> 2
    113'd2,                 // full width min is s=112, truncated tie -> 0 (R3)
    113'd1 << 43            // first zero score at s=70 -> 70
  };
  localparam logic [M-1:0] TY [NV] = '{
    113'h1F, 113'hABCDEF, 113'h1234_5678_9ABC, 113'h1,
    {1'b1, 112'h5}, 113'hF0F0_F0F0, 113'h8_0000_0000_0001
  };
  localparam int TI [NV] = '{0, 0, 1, 0, 2, 0, 70};

  logic          clk = 1'b0;
  logic          rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [M-1:0]  in_x, in_y, out_x, out_y;
  logic [6:0]    out_idx;

  always #10 clk = ~clk;

  frobenius_canon #(.M(M), .T(T)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_x (in_x), .in_y (in_y),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_x (out_x), .out_y (out_y), .out_idx (out_idx)
  );

  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int wr = 0, rd = 0, bp_mode = 0;
  logic done = 1'b0;
  logic [M-1:0] ex_x [256];
  logic [M-1:0] ex_y [256];
  int           ex_i [256];

  function automatic logic [M-1:0] rotv(logic [M-1:0] v, int s);
    logic [M-1:0] r;
    for (int b = 0; b < M; b++) r[b] = v[(b - s + M) % M];
    return r;
  endfunction

  function automatic int ref_idx(logic [M-1:0] v);
    int best = 0;
    logic [M-1:0] r;
    logic [T-1:0] bk, k;
    r  = rotv(v, 0);
    bk = r[M-1 -: T];
    for (int i = 1; i < M; i++) begin
      r = rotv(v, i);
      k = r[M-1 -: T];
      if (k < bk) begin bk = k; best = i; end
    end
    return best;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    mchecks++;
    if (!ok) begin
      merrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [M-1:0] x, input logic [M-1:0] y, input int s);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_y = y;
    while (!in_ready) @(negedge clk);
    ex_x[wr % 256] = rotv(x, s);
    ex_y[wr % 256] = rotv(y, s);
    ex_i[wr % 256] = s;
    wr++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (rd != wr && t < 3000) begin @(negedge clk); t++; end
    chk(rd == wr, "R7 drain", M'(rd), M'(wr));
    repeat (LAT + 2) @(negedge clk);
    chk(out_valid == 1'b0, "R7 no extra result", M'(out_valid), M'(0));
  endtask

  function automatic logic [M-1:0] rnd();
    logic [127:0] w;
    w = {$urandom, $urandom, $urandom, $urandom};
    return w[M-1:0];
  endfunction

  // sink readiness changes well away from both clock edges
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #5;
      case (bp_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom_range(1, 0));
        default: out_ready = 1'b0;
      endcase
    end
  end

  // output monitor
  logic         held = 1'b0;
  logic [M-1:0] hx, hy;
  logic [6:0]   hi;
  always @(negedge clk) begin
    if (!rst_n) begin
      rd   = wr;
      held = 1'b0;
    end else begin
      if (held) begin
        mchk(out_valid && out_x == hx && out_y == hy && out_idx == hi,
             "R6 outputs held under stall", out_x, hx);
      end
      if (out_valid && out_ready) begin
        mchk(rd < wr, "R7 unexpected result", M'(rd), M'(wr));
        mchk(int'(out_idx) == ex_i[rd % 256], "R2 R3 rotation count",
             M'(out_idx), M'(ex_i[rd % 256]));
        mchk(out_x == ex_x[rd % 256], "R1 canonical x", out_x, ex_x[rd % 256]);
        mchk(out_y == ex_y[rd % 256], "R4 rotated y", out_y, ex_y[rd % 256]);
        rd++;
      end
      held = out_valid && !out_ready;
      hx = out_x; hy = out_y; hi = out_idx;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL R7 watchdog actual=%0d expected=%0d", rd, wr);
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [M-1:0] x, y;
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid low in reset", M'(out_valid), M'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after reset", M'(in_ready), M'(1));
    chk(out_valid == 1'b0, "R8 valid after reset", M'(out_valid), M'(0));

    // table walk: rotation choice, truncation ties, y rotation (R1 R2 R3 R4)
    for (int n = 0; n < NV; n++) send(TX[n], TY[n], TI[n]);
    idle();
    drain();

    // model agrees with hand table for the R3 truncated tie
    chk(ref_idx(TX[5]) == 0, "R3 truncated tie model", M'(ref_idx(TX[5])), M'(0));

    // random points under random back-pressure (R2 R6 R7)
    bp_mode = 1;
    for (int n = 0; n < 40; n++) begin
      x = rnd(); y = rnd();
      send(x, y, ref_idx(x));
    end
    idle();
    bp_mode = 0;
    drain();

    // R5 fixed latency
    @(negedge clk);
    x = rnd(); y = rnd();
    in_valid = 1'b1; in_x = x; in_y = y;
    ex_x[wr % 256] = rotv(x, ref_idx(x));
    ex_y[wr % 256] = rotv(y, ref_idx(x));
    ex_i[wr % 256] = ref_idx(x);
    wr++;
    cnt = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      cnt++;
    end while (!out_valid && cnt < 20);
    chk(cnt == LAT, "R5 latency", M'(cnt), M'(LAT));
    drain();

    // R6 fill the pipeline with the sink stalled
    bp_mode = 2;
    repeat (2) @(negedge clk);
    for (int n = 0; n < LAT; n++) begin
      x = rnd(); y = rnd();
      send(x, y, ref_idx(x));
    end
    idle();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b1, "R6 result waits", M'(out_valid), M'(1));
    chk(in_ready == 1'b0, "R6 input blocked", M'(in_ready), M'(0));
    bp_mode = 0;
    drain();

    // R8 reset with points in flight, then a clean restart
    for (int n = 0; n < 3; n++) send(TX[n + 2], TY[n], TI[n + 2]);
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R8 flush on reset", M'(out_valid), M'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after flush", M'(in_ready), M'(1));
    send(TX[6], TY[6], TI[6]);
    idle();
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end
endmodule